// File: doc/BRIEF.md
# SAR Converter Controller

This block is the digital half of a 12-bit successive-approximation converter. A host bus drives a chip select, a read strobe and a byte-select input, all active on the same clock as the block. A read with all three low requests a conversion; the controller then clears its approximation register, waits one settling cycle and resolves the result one bit per clock from the most significant bit down. It presents a trial code to an external DAC and reads back a single comparator bit that says whether the analog input lies at or above that trial level.

When the last bit is resolved the result is copied into an output latch, and the ready flag returns high on that same edge. A host can run in either of two ways. It can hold the read strobe low through the conversion and collect the new result once ready rises. Or it can issue short reads that each start a conversion and return the previous result. The result is presented either as one 12-bit word or, for an 8-bit host, as two byte reads selected by the byte-select input. The pads are modelled by an output-enable signal. While that enable is low, the data lines are driven to zero.

Top module: `sarc_top`

## Requirements
- R1: A conversion is accepted only on a clock edge where cs_n, rd_n and hben are all 0; a read with hben = 1, or with cs_n = 1, never starts one.
- R2: A start is an edge event: keeping cs_n, rd_n and hben low after a conversion finishes does not start another; the request must first be withdrawn.
- R3: On the accepting edge, ready falls and the approximation register is cleared, so trial_code reads 0 in the first busy cycle.
- R4: A new start request made while a conversion is running is ignored; that conversion completes on its normal schedule with its normal result.
- R5: ready stays low for exactly SETTLE_CYC + 12 + 1 = 14 cycles; the result latch is written on the edge where ready returns high.
- R6: Bits are resolved MSB first: the first bit cycle presents trial_code = 12'h800, and with a comparator reporting input >= trial the final result equals the input code.
- R7: The result latch keeps the previous result throughout a conversion, and the data lines show that previous result while enabled; after reset the latch holds 0.
- R8: With hben = 0, data_out[11:0] carries the whole result. With hben = 1, data_out[7:4] are 0 and data_out[3:0] carry result bits 11..8.
- R9: Whenever data_oe is 1, data_out[11:8] equal result bits 11..8, whatever the value of hben.
- R10: data_oe is 1 only while cs_n and rd_n are both 0. While data_oe is 0, data_out is all zero.
- R11: After reset, ready is 1, and a read without a start returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | Byte select: 1 reads the high byte and blocks conversion start |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above trial_code |
| trial_code | output | 12 | Code presented to the DAC |
| ready | output | 1 | 1 when idle, 0 while converting |
| data_out | output | 12 | Data bus value (zero while not enabled) |
| data_oe | output | 1 | Bus drive enable |

## Verification
On every cycle, the assertions check four things. Every fall of ready follows a qualified start request. The first busy cycle shows a cleared trial code. The result latch holds steady while busy. Each busy period lasts exactly 14 cycles. They also check the bus rules on every cycle: the enable is tied to the strobes, the top four lines carry the MSBs, and the high-byte read is zero-filled. Only the bench scenarios can show the results that depend on data. These are that the SAR converges to the modelled input code, that the trial sequence opens at mid-scale, and that a restart request in mid-conversion leaves both timing and result unchanged. The bench scenarios also show that a request held low across completion does not start a second conversion.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_BITS   = 2'd2,
    ST_LOAD   = 2'd3
  } sarc_state_e;
endpackage

// File: rtl/sarc_rst_sync.sv
module sarc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sarc_start_detect.sv
module sarc_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic hben,
  output logic start_pulse,
  output logic rd_en
);
  logic req;
  logic req_q;

  // all three strobes low form a request; only its rising edge counts
  assign req   = ~cs_n & ~rd_n & ~hben;
  assign rd_en = ~cs_n & ~rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign start_pulse = req & ~req_q;
endmodule

// File: rtl/sarc_seq.sv
module sarc_seq
  import sarc_pkg::*;
#(
  parameter int W          = 12,
  parameter int SETTLE_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_pulse,
  input  logic         cmp_hi,
  output logic [W-1:0] trial_code,
  output logic [W-1:0] sar_val,
  output logic         load_en,
  output logic         ready
);
  localparam int MAXC = (W > SETTLE_CYC) ? W : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  sarc_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  sar_q, sar_d;
  logic          ready_q, ready_d;
  logic [W-1:0]  trial_bit;

  assign trial_bit = {{(W-1){1'b0}}, 1'b1} << cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sar_d   = sar_q;
    ready_d = ready_q;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_pulse) begin
          state_d = ST_SETTLE;
          cnt_d   = CW'(SETTLE_CYC - 1);
          sar_d   = '0;
          ready_d = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          state_d = ST_BITS;
          cnt_d   = CW'(W - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_BITS: begin
        sar_d[cnt_q] = cmp_hi;
        if (cnt_q == '0) state_d = ST_LOAD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_LOAD: begin
        load_en = 1'b1;
        ready_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sar_q   <= '0;
      ready_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sar_q   <= sar_d;
      ready_q <= ready_d;
    end
  end

  assign trial_code = (state_q == ST_BITS) ? (sar_q | trial_bit) : sar_q;
  assign sar_val    = sar_q;
  assign ready      = ready_q;
endmodule

// File: rtl/sarc_out_mux.sv
module sarc_out_mux #(
  parameter int W     = 12,
  parameter int LOW_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] sar_val,
  input  logic         rd_en,
  input  logic         hben,
  output logic [W-1:0] data_out,
  output logic         data_oe,
  output logic [W-1:0] result_q
);
  localparam int HI_W = W - LOW_W;

  logic [W-1:0]     latch_q;
  logic [LOW_W-1:0] low_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (load_en) latch_q <= sar_val;
  end

  // high-byte view: upper bits zero-extended onto the low lines
  assign low_view = hben ? {{(LOW_W-HI_W){1'b0}}, latch_q[W-1:LOW_W]}
                         : latch_q[LOW_W-1:0];

  assign data_out = rd_en ? {latch_q[W-1:LOW_W], low_view} : '0;
  assign data_oe  = rd_en;
  assign result_q = latch_q;
endmodule

// File: rtl/sarc_top.sv
module sarc_top #(
  parameter int W          = 12,
  parameter int LOW_W      = 8,
  parameter int SETTLE_CYC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         hben,
  input  logic         cmp_hi,
  output logic [W-1:0] trial_code,
  output logic         ready,
  output logic [W-1:0] data_out,
  output logic         data_oe
);
  logic         srst_n;
  logic         start_pulse;
  logic         rd_en;
  logic         load_en;
  logic [W-1:0] sar_val;
  logic [W-1:0] result_q;

  sarc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  sarc_start_detect u_start (
    .clk(clk), .rst_n(srst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .start_pulse(start_pulse), .rd_en(rd_en)
  );

  sarc_seq #(.W(W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(srst_n), .start_pulse(start_pulse), .cmp_hi(cmp_hi),
    .trial_code(trial_code), .sar_val(sar_val), .load_en(load_en),
    .ready(ready)
  );

  sarc_out_mux #(.W(W), .LOW_W(LOW_W)) u_out (
    .clk(clk), .rst_n(srst_n), .load_en(load_en), .sar_val(sar_val),
    .rd_en(rd_en), .hben(hben), .data_out(data_out), .data_oe(data_oe),
    .result_q(result_q)
  );
endmodule

// File: rtl/sarc_chk.sv
module sarc_chk #(
  parameter int W          = 12,
  parameter int LOW_W      = 8,
  parameter int SETTLE_CYC = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         rd_n,
  input logic         hben,
  input logic [W-1:0] trial_code,
  input logic         ready,
  input logic [W-1:0] data_out,
  input logic         data_oe,
  input logic [W-1:0] result_q
);
  localparam int HI_W     = W - LOW_W;
  localparam int BUSY_LEN = SETTLE_CYC + W + 1;

  logic [15:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (!ready) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(!cs_n && !rd_n && !hben)); // R1

  AST_SAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> trial_code == '0); // R3

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == 16'(BUSY_LEN)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(result_q)); // R7

  AST_HB_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && hben) |-> data_out[LOW_W-1:HI_W] == '0); // R8

  AST_MSB_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> data_out[W-1:LOW_W] == result_q[W-1:LOW_W]); // R9

  AST_OE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !data_oe); // R10

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0); // R10
endmodule

bind sarc_top sarc_chk #(.W(W), .LOW_W(LOW_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
  .trial_code(trial_code), .ready(ready), .data_out(data_out),
  .data_oe(data_oe), .result_q(result_q)
);

// File: tb/sarc_top_test.sv
`timescale 1ns/1ps
module sarc_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rd_n, hben;
  logic        cmp_hi;
  logic [11:0] trial_code;
  logic        ready;
  logic [11:0] data_out;
  logic        data_oe;
  logic [11:0] ain;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {input code, expected high-byte read}
  localparam logic [23:0] VEC [8] = '{
    {12'h000, 12'h000}, {12'hFFF, 12'hF0F}, {12'h800, 12'h808},
    {12'h7FF, 12'h707}, {12'h555, 12'h505}, {12'hAAA, 12'hA0A},
    {12'h001, 12'h000}, {12'hA5C, 12'hA0A}
  };

  always #2.5 clk = ~clk;

  // behavioural comparator: input at or above the trial level
  assign cmp_hi = (ain >= trial_code);

  sarc_top uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .cmp_hi(cmp_hi), .trial_code(trial_code), .ready(ready),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // full slow-read conversion; returns with strobes released unless hold
  task automatic convert(input logic [11:0] code, input logic [11:0] prev,
                         input bit hold);
    @(negedge clk);
    ain  = code;
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    #1 chk(data_oe && data_out == prev, "R7 old data on bus", data_out, prev);
    @(negedge clk);
    chk(ready == 1'b0, "R3 ready falls", ready, 0);
    chk(trial_code == 12'h000, "R3 sar cleared", trial_code, 0);
    chk(data_out == prev, "R7 latch holds", data_out, prev);
    @(negedge clk);
    chk(trial_code == 12'h800, "R6 msb trial", trial_code, 12'h800);
    repeat (12) @(negedge clk);
    chk(ready == 1'b0, "R5 still busy", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R5 ready returns", ready, 1);
    chk(data_out == code, "R6 result", data_out, code);
    if (!hold) begin
      cs_n = 1'b1; rd_n = 1'b1;
    end
  endtask

  initial begin
    logic [11:0] prev;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0; ain = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R11 reset ready", ready, 1);
    chk(data_oe == 1'b0 && data_out == 12'h0, "R11 bus idle", data_out, 0);

    // read with hben high: no start, latch zero
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
    #1 chk(data_oe && data_out == 12'h000, "R11 reset latch zero", data_out, 0);
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R1 hben blocks start", ready, 1);
    cs_n = 1'b1; hben = 1'b0;
    repeat (5) @(negedge clk);
    chk(ready == 1'b1, "R1 cs high blocks start", ready, 1);
    chk(data_oe == 1'b0 && data_out == 12'h0, "R10 disabled bus zero", data_out, 0);
    rd_n = 1'b1;

    prev = 12'h000;
    for (int i = 0; i < 8; i++) begin
      convert(VEC[i][23:12], prev, 1'b0);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
      #1 chk(data_out == VEC[i][11:0], "R8 high byte read", data_out, VEC[i][11:0]);
      chk(data_out[11:8] == VEC[i][23:20], "R9 msb lines", data_out[11:8], VEC[i][23:20]);
      @(negedge clk);
      chk(ready == 1'b1, "R1 hben read no start", ready, 1);
      cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
      prev = VEC[i][23:12];
    end

    // held request across completion
    convert(12'h3C6, prev, 1'b1);
    repeat (20) @(negedge clk);
    chk(ready == 1'b1, "R2 held request no restart", ready, 1);
    chk(data_out == 12'h3C6, "R2 result kept", data_out, 12'h3C6);
    cs_n = 1'b1; rd_n = 1'b1;
    prev = 12'h3C6;

    // restart attempt mid-conversion
    @(negedge clk);
    ain = 12'h9E1; cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b1;
    @(negedge clk);
    rd_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(ready == 1'b0, "R4 restart ignored, still busy", ready, 0);
    @(negedge clk);
    chk(ready == 1'b1, "R4 completes on schedule", ready, 1);
    chk(data_out == 12'h9E1, "R4 result intact", data_out, 12'h9E1);
    cs_n = 1'b1; rd_n = 1'b1;
    #1 chk(data_oe == 1'b0 && data_out == 12'h0, "R10 released bus", data_out, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end
endmodule